// File: doc/BRIEF.md
# System Control Port with Timer Gate and Refresh Status

A single 8-bit control and status register that sits next to an interval timer. A write drives two control bits. One bit is the count gate of timer channel 2. The other bit is an enable for the speaker data path. A read returns a status byte. That byte merges the two control bits, the live OUT level of timer channel 2, and a refresh bit. The refresh bit toggles on its own at a fixed interval that a parameter sets.

The port also flags a gate rising edge toward the timer. When a write raises the channel 2 gate while that channel runs in a mode that restarts on a gate edge, the port raises a one-cycle retrigger pulse. The gates of timer channels 0 and 1 are not under software control here and stay high. A synchronous, active-low reset clears the channel 2 gate, the data enable, the refresh phase and the read register.

Top module: `sys_ctl_port`

## Requirements
- R1: During and after a synchronous reset (rstN low at a clock edge), gate2, spkDataEn, retrig2 and rdData are 0, and the refresh bit restarts at 0.
- R2: A write (wrEn high at a clock edge) sets gate2 to wrData bit 0 and spkDataEn to wrData bit 1 from the next cycle on. Other wrData bits have no effect.
- R3: A read (rdEn high at a clock edge) loads rdData on that edge, with the values held just before the edge. Bit 0 carries gate2, bit 1 spkDataEn, bit 4 the refresh bit and bit 5 tmr2Out. rdData holds its value when no read occurs, and a read in the same cycle as a write returns the pre-write control bits.
- R4: rdData bits 2, 3, 6 and 7 always read 0.
- R5: The refresh bit starts at 0 and inverts after every REFRESH_HALF clock edges counted from reset release. With the default of 1500 at 100 MHz, that is one inversion every 15 us.
- R6: retrig2 is high for exactly the one cycle in which gate2 first reads 1 after a write that raised it from 0, provided tmr2Mode (3-bit mode code) is 1, 2, 3, 5, 6 or 7. Codes 6 and 7 act as 2 and 3. It stays 0 for codes 0 and 4, and for writes that leave gate2 at 1.
- R7: Without a write, gate2 and spkDataEn keep their values.
- R8: gate0 and gate1, the gates of timer channels 0 and 1, are 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe for the control bits |
| rdEn | input | 1 | Read strobe for the status byte |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered status byte |
| tmr2Mode | input | 3 | Current operating mode code of timer channel 2 |
| tmr2Out | input | 1 | OUT level of timer channel 2 |
| gate0 | output | 1 | Gate of timer channel 0, held high |
| gate1 | output | 1 | Gate of timer channel 1, held high |
| gate2 | output | 1 | Gate of timer channel 2 |
| spkDataEn | output | 1 | Speaker data enable |
| retrig2 | output | 1 | One-cycle retrigger pulse on a gate rising edge in an edge-restart mode |

## Verification
The assertions assume that wrEn, rdEn, wrData and tmr2Mode are clean, synchronous levels that are only sampled at clock edges. They also assume that tmr2Mode does not change in the same cycle as a gate-raising write. The stimulus changes every input on the falling clock edge, so each input is stable across the next rising edge. The stimulus keeps the mode steady throughout each write. It includes simultaneous read and write strobes, since both the design and the properties define what happens in that case.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;

  // Bit positions in the status byte and the write byte.
  localparam int BIT_GATE    = 0;
  localparam int BIT_DATAEN  = 1;
  localparam int BIT_REFRESH = 4;
  localparam int BIT_OUT     = 5;

  typedef struct packed {
    logic wrCtl;
    logic rdStat;
  } ctlStrobes_t;

  // Modes that restart counting on a gate rising edge (6/7 alias 2/3).
  function automatic logic edgeRestartMode(input logic [MODE_W-1:0] m);
    return (m != 3'd0) && (m != 3'd4);
  endfunction
endpackage

// File: rtl/sys_ctl_refresh.sv
module sys_ctl_refresh #(
  parameter int REFRESH_HALF = 1500
) (
  input  logic clk,
  input  logic rstN,
  output logic refreshBit
);
  localparam int CNT_W = (REFRESH_HALF > 2) ? $clog2(REFRESH_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_HALF - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt     <= '0;
      refreshBit <= 1'b0;
    end else if (divCnt == LAST) begin
      divCnt     <= '0;
      refreshBit <= ~refreshBit;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sys_ctl_ctrl.sv
module sys_ctl_ctrl
  import sys_ctl_pkg::*;
(
  input  logic        wrEn,
  input  logic        rdEn,
  output ctlStrobes_t strb
);
  always_comb begin
    strb.wrCtl  = wrEn;
    strb.rdStat = rdEn;
  end
endmodule

// File: rtl/sys_ctl_datapath.sv
module sys_ctl_datapath
  import sys_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MODE_W-1:0] chMode,
  input  logic              chOut,
  input  logic              refreshBit,
  output logic              gateReg,
  output logic              dataEnReg,
  output logic              retrigPulse,
  output logic [DATA_W-1:0] statusReg
);
  logic [DATA_W-1:0] statusNext;
  logic              riseNext;

  always_comb begin
    statusNext              = '0;
    statusNext[BIT_GATE]    = gateReg;
    statusNext[BIT_DATAEN]  = dataEnReg;
    statusNext[BIT_REFRESH] = refreshBit;
    statusNext[BIT_OUT]     = chOut;
    riseNext = strb.wrCtl & wrData[BIT_GATE] & ~gateReg & edgeRestartMode(chMode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateReg     <= 1'b0;
      dataEnReg   <= 1'b0;
      retrigPulse <= 1'b0;
      statusReg   <= '0;
    end else begin
      retrigPulse <= riseNext;
      if (strb.wrCtl) begin
        gateReg   <= wrData[BIT_GATE];
        dataEnReg <= wrData[BIT_DATAEN];
      end
      if (strb.rdStat) statusReg <= statusNext;
    end
  end
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import sys_ctl_pkg::*;
#(
  parameter int REFRESH_HALF = 1500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [2:0] tmr2Mode,
  input  logic       tmr2Out,
  output logic       gate0,
  output logic       gate1,
  output logic       gate2,
  output logic       spkDataEn,
  output logic       retrig2
);
  ctlStrobes_t strb;
  logic        refreshBit;

  assign gate0 = 1'b1;
  assign gate1 = 1'b1;

  sys_ctl_ctrl u_ctrl (.wrEn(wrEn), .rdEn(rdEn), .strb(strb));

  sys_ctl_refresh #(.REFRESH_HALF(REFRESH_HALF)) u_refresh (
    .clk(clk), .rstN(rstN), .refreshBit(refreshBit));

  sys_ctl_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .chMode(tmr2Mode), .chOut(tmr2Out), .refreshBit(refreshBit),
    .gateReg(gate2), .dataEnReg(spkDataEn), .retrigPulse(retrig2),
    .statusReg(rdData));
endmodule

// File: rtl/sys_ctl_port_chk.sv
module sys_ctl_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       tmr2Out,
  input logic       gate2,
  input logic       spkDataEn,
  input logic       retrig2
);
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (gate2 == $past(wrData[0])) && (spkDataEn == $past(wrData[1]))); // R2
  AST_READ_CTL_BITS: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (rdData[1:0] == {$past(spkDataEn), $past(gate2)}) && (rdData[5] == $past(tmr2Out))); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R3
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7:6] == 2'b00) && (rdData[3:2] == 2'b00)); // R4
  AST_RETRIG_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    retrig2 |-> (gate2 && !$past(gate2))); // R6
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(gate2) && $stable(spkDataEn)); // R7
endmodule

bind sys_ctl_port sys_ctl_port_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
  .rdData(rdData), .tmr2Out(tmr2Out), .gate2(gate2),
  .spkDataEn(spkDataEn), .retrig2(retrig2));

// File: tb/sim_sys_ctl_port.sv
module sim_sys_ctl_port;
  localparam int HALF = 20;
  localparam int NVEC = 10;
  // Vector fields: {wr[12], data[11:4], mode[3:1], out[0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 8'h01, 3'd1, 1'b1},  // raise gate, mode 1: retrigger
    {1'b1, 8'h03, 3'd2, 1'b0},  // gate stays high: no pulse
    {1'b1, 8'h00, 3'd2, 1'b1},  // drop gate
    {1'b1, 8'h01, 3'd0, 1'b0},  // raise in mode 0: no pulse
    {1'b1, 8'hFC, 3'd3, 1'b1},  // high bits ignored, gate low
    {1'b1, 8'h01, 3'd4, 1'b1},  // raise in mode 4: no pulse
    {1'b0, 8'hFF, 3'd5, 1'b0},  // no write: hold
    {1'b1, 8'h02, 3'd5, 1'b0},  // gate low, enable high
    {1'b1, 8'h01, 3'd7, 1'b1},  // raise in mode 7: retrigger
    {1'b1, 8'hF1, 3'd5, 1'b0}   // raise? no, already high
  };

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, tmr2Out = 0;
  logic [7:0] wrData = 0;
  logic [2:0] tmr2Mode = 0;
  logic [7:0] rdData;
  logic gate0, gate1, gate2, spkDataEn, retrig2;
  int cyc = 0, nChk = 0, nFail = 0;
  logic mGate = 0, mEn = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  sys_ctl_port #(.REFRESH_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .tmr2Mode(tmr2Mode), .tmr2Out(tmr2Out), .gate0(gate0),
    .gate1(gate1), .gate2(gate2), .spkDataEn(spkDataEn), .retrig2(retrig2));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic refExp();
    return logic'((cyc / HALF) % 2);
  endfunction

  // Issue a read on the next edge; compare at the following falling edge.
  task automatic doRead(input string req, input logic o);
    logic [7:0] e;
    tmr2Out = o; rdEn = 1;
    e = {2'b00, o, refExp(), 2'b00, mEn, mGate};
    @(negedge clk); rdEn = 0;
    check(req, rdData, e);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset gate2/en/retrig", {5'b0, gate2, spkDataEn, retrig2}, 8'h00);
    check("R1 reset rdData", rdData, 8'h00);
    check("R8 gates 0/1 high", {6'b0, gate0, gate1}, 8'h03);
    rstN = 1;
    doRead("R1 R5 refresh starts low", 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic expRise;
      wrEn = VEC[i][12]; wrData = VEC[i][11:4]; tmr2Mode = VEC[i][3:1];
      expRise = wrEn & wrData[0] & ~mGate & (tmr2Mode != 0) & (tmr2Mode != 4);
      if (wrEn) begin mGate = wrData[0]; mEn = wrData[1]; end
      @(negedge clk); wrEn = 0;
      check("R2 R7 control bits", {6'b0, spkDataEn, gate2}, {6'b0, mEn, mGate});
      check("R6 retrigger pulse", {7'b0, retrig2}, {7'b0, expRise});
      doRead("R3 R4 status byte", VEC[i][0]);
      check("R6 pulse is one cycle", {7'b0, retrig2}, 8'h00);
    end

    // Read and write together: read returns pre-write bits (R3)
    wrEn = 1; wrData = 8'h00; rdEn = 1; tmr2Out = 1;
    begin
      logic [7:0] e;
      e = {2'b00, 1'b1, refExp(), 2'b00, mEn, mGate};
      mGate = 0; mEn = 0;
      @(negedge clk); wrEn = 0; rdEn = 0;
      check("R3 read with write", rdData, e);
    end
    // rdData holds without read (R3)
    tmr2Out = 0;
    repeat (HALF) @(negedge clk);
    check("R3 hold without read", rdData[5], 1'b1);

    // Refresh boundary (R5): read straddling an inversion
    while ((cyc % HALF) != HALF - 1) @(negedge clk);
    doRead("R5 refresh before inversion", 1'b0);
    doRead("R5 refresh after inversion", 1'b0);
    repeat (HALF + 3) @(negedge clk);
    doRead("R5 refresh later", 1'b0);

    // Mid-run reset (R1)
    wrEn = 1; wrData = 8'h03; mGate = 1; mEn = 1;
    @(negedge clk); wrEn = 0;
    doRead("R3 status before reset", 1'b0);
    rstN = 0; mGate = 0; mEn = 0;
    @(negedge clk);
    check("R1 sync reset clears", {5'b0, gate2, spkDataEn, retrig2}, 8'h00);
    check("R1 sync reset rdData", rdData, 8'h00);
    check("R8 gates during reset", {6'b0, gate0, gate1}, 8'h03);
    rstN = 1;
    repeat (HALF - 1) @(negedge clk);
    doRead("R1 R5 refresh restarted", 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule